// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block is the digital control core of a synchronous buck power stage. It takes an already decoded three-level switching command (drive high, drive low or float), two supply-good flags (bias rail and gate-drive rail), an enable input and a mode strap. It also takes synchronous comparator flags that report whether each gate is below its turn-on threshold and whether the switch node is low. It produces the enables for the high-side and low-side gate drivers, a latched copy of the selected input mode, a ready flag and a sticky dead-time fault flag.

Dead time is adaptive. A gate is turned on only after the comparator flags show that the opposite device is really off, and a turn-off is always issued before the matching turn-on. Outputs stay off until both rails are good and enable is high. In tri-level mode the stage also stays idle until the command has been seen leaving the float level. This keeps a controller that is still starting up from driving the bridge with undefined levels. A wait for a flag that never arrives is cut off after a parameterized number of cycles. The bridge then stays off and a fault is latched until enable is cycled.

Top module: `hb_gate_seq`

## Requirements
- R1: When either `bias_ok_i` or `drv_ok_i` is low, both `hs_on_o` and `ls_on_o` are low from the next clock edge onward.
- R2: When `en_i` is low, both gate outputs are low from the next clock edge onward, whatever `cmd_i` is.
- R3: `mode_o` takes the value of `mode_strap_i` at the clock edge after a rising edge of `en_i` or of `bias_ok_i`, and at no other time. A strap value of 1 selects tri-level mode and 0 selects standard mode.
- R4: In tri-level mode, after rails are good and enable is high, both gates stay off until `cmd_i` has been at float (encoding 2'b10 or 2'b11) and then moves to drive-high (2'b01) or drive-low (2'b00). Later floats do not re-arm or disarm the stage.
- R5: In standard mode, switching is allowed one edge after rails are good and enable is high, with no float exit required.
- R6: On drive-low, `hs_on_o` goes low first. `ls_on_o` rises only on an edge where `hs_on_o` was already low, the command was drive-low, `hs_gate_low_i` was 1 and `sw_low_i` was 1.
- R7: On drive-high, `ls_on_o` goes low first. `hs_on_o` rises only on an edge where `ls_on_o` was already low and `ls_gate_low_i` was 1.
- R8: A float command turns both gates off on the next edge. The next drive-high or drive-low command resumes switching without re-arming.
- R9: `hs_on_o` and `ls_on_o` are never high in the same cycle.
- R10: If a dead-time wait lasts more than `TIMEOUT` cycles, `fault_o` rises and both gates stay off. The fault holds while `en_i` is high and clears on the edge after `en_i` is low.
- R11: `ready_o` rises exactly `READY_CYC` edges after rails are good and enable is high, and falls on the edge after any of them drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Switching command: 00 low, 01 high, 1x float |
| bias_ok_i | input | 1 | Bias rail above its undervoltage threshold |
| drv_ok_i | input | 1 | Gate-drive rail above its undervoltage threshold |
| en_i | input | 1 | Stage enable |
| mode_strap_i | input | 1 | Mode strap: 1 tri-level, 0 standard |
| hs_gate_low_i | input | 1 | High-side gate is below its threshold |
| ls_gate_low_i | input | 1 | Low-side gate is below its threshold |
| sw_low_i | input | 1 | Switch node is low |
| hs_on_o | output | 1 | High-side gate driver enable |
| ls_on_o | output | 1 | Low-side gate driver enable |
| mode_o | output | 1 | Latched mode |
| ready_o | output | 1 | Startup window elapsed |
| fault_o | output | 1 | Sticky dead-time timeout fault |

## Verification
A wrong arming state shows up as a gate that switches, or stays silent, within two edges of the first active command after enable. A wrong latched mode is visible directly on `mode_o` one edge after an enable or bias-rail rise. A broken dead-time state shows up as a gate that rises in the same edge as its partner falls, or before the comparator flag allows it. That is observable on the very edge it happens, so random flag delays are checked edge by edge against the previous cycle's inputs and outputs. A stuck timeout counter shows up as `fault_o` rising too early, or not at all, around the `TIMEOUT` boundary.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [1:0] {
        CMD_LOW   = 2'b00,
        CMD_HIGH  = 2'b01,
        CMD_FLT   = 2'b10,
        CMD_FLT_B = 2'b11
    } hb_cmd_e;

    localparam logic MODE_STD = 1'b0;
    localparam logic MODE_TRI = 1'b1;

    function automatic logic cmd_is_float(input logic [1:0] c);
        return c[1];
    endfunction

endpackage

// File: rtl/hb_mode_latch.sv
module hb_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bias_ok_i,
    input  logic strap_i,
    output logic mode_now_o,
    output logic mode_o
);

    typedef struct packed {
        logic en_prev;
        logic bias_prev;
        logic mode;
    } ml_state_t;

    ml_state_t s_d, s_q;
    logic      sample_evt;

    always_comb begin
        s_d           = s_q;
        sample_evt    = (en_i & ~s_q.en_prev) | (bias_ok_i & ~s_q.bias_prev);
        mode_now_o    = sample_evt ? strap_i : s_q.mode;
        s_d.en_prev   = en_i;
        s_d.bias_prev = bias_ok_i;
        s_d.mode      = mode_now_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode_o = s_q.mode;

    // R3: without a rising edge on enable or bias rail the mode is frozen
    p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && $past(en_i, 2) && $past(bias_ok_i) && $past(bias_ok_i, 2))
        |-> $stable(mode_o));

endmodule

// File: rtl/hb_arm_ctrl.sv
module hb_arm_ctrl #(
    parameter int READY_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       tri_mode_i,
    input  logic [1:0] cmd_i,
    output logic       go_o,
    output logic       ready_o
);
    import hb_gate_pkg::*;

    localparam int RCW = $clog2(READY_CYC + 1);

    typedef struct packed {
        logic           seen_flt;
        logic           armed;
        logic [RCW-1:0] cnt;
    } arm_state_t;

    arm_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!active_i) begin
            s_d = '0;
        end else begin
            if (!s_q.armed) begin
                if (tri_mode_i == MODE_STD)
                    s_d.armed = 1'b1;
                else if (s_q.seen_flt && !cmd_is_float(cmd_i))
                    s_d.armed = 1'b1;
            end
            if (cmd_is_float(cmd_i))
                s_d.seen_flt = 1'b1;
            if (s_q.cnt != RCW'(READY_CYC))
                s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign go_o    = s_q.armed & active_i;
    assign ready_o = (s_q.cnt == RCW'(READY_CYC));

    // R4: in tri-level mode arming only happens on a non-float command
    p_arm_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tri_mode_i) && $rose(s_q.armed)) |-> !cmd_is_float($past(cmd_i)));

    // R5: standard mode arms on the edge after the stage becomes active
    p_std_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && tri_mode_i == MODE_STD) |=> s_q.armed);

    // R11: ready drops once the stage is no longer active
    p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !ready_o);

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
    parameter int TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       en_i,
    input  logic [1:0] cmd_i,
    input  logic       hs_gl_i,
    input  logic       ls_gl_i,
    input  logic       sw_low_i,
    output logic       hs_o,
    output logic       ls_o,
    output logic       fault_o
);
    import hb_gate_pkg::*;

    localparam int TCW = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic           hs;
        logic           ls;
        logic           fault;
        logic [TCW-1:0] wcnt;
    } dt_state_t;

    dt_state_t s_d, s_q;
    logic      waiting;

    always_comb begin
        s_d     = s_q;
        waiting = 1'b0;
        if (!go_i || s_q.fault) begin
            s_d.hs = 1'b0;
            s_d.ls = 1'b0;
        end else begin
            unique case (hb_cmd_e'(cmd_i))
                CMD_HIGH: begin
                    s_d.ls = 1'b0;
                    if (!s_q.hs) begin
                        if (!s_q.ls && ls_gl_i) s_d.hs = 1'b1;
                        else                    waiting = 1'b1;
                    end
                end
                CMD_LOW: begin
                    s_d.hs = 1'b0;
                    if (!s_q.ls) begin
                        if (!s_q.hs && hs_gl_i && sw_low_i) s_d.ls = 1'b1;
                        else                                waiting = 1'b1;
                    end
                end
                default: begin
                    s_d.hs = 1'b0;
                    s_d.ls = 1'b0;
                end
            endcase
        end

        if (waiting) begin
            if (s_q.wcnt >= TCW'(TIMEOUT)) begin
                s_d.fault = 1'b1;
                s_d.hs    = 1'b0;
                s_d.ls    = 1'b0;
            end else begin
                s_d.wcnt = s_q.wcnt + 1'b1;
            end
        end else begin
            s_d.wcnt = '0;
        end

        if (!en_i) s_d.fault = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hs_o    = s_q.hs;
    assign ls_o    = s_q.ls;
    assign fault_o = s_q.fault;

    // R9: never both gates on
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));

    // R6: low-side turn-on needs high side off, its gate low and switch node low
    p_ls_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_o) |-> $past(!hs_o && hs_gl_i && sw_low_i && cmd_i == CMD_LOW));

    // R7: high-side turn-on needs low side off and its gate low
    p_hs_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_o) |-> $past(!ls_o && ls_gl_i && cmd_i == CMD_HIGH));

    // R8: float command clears both gates
    p_float_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_is_float(cmd_i) |=> (!hs_o && !ls_o));

    // R2: enable low clears both gates
    p_en_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!hs_o && !ls_o));

    // R10: fault keeps the bridge off and holds while enabled
    p_fault_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!hs_o && !ls_o));
    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && en_i) |=> fault_o);

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
    parameter int READY_CYC = 8,
    parameter int TIMEOUT   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd_i,
    input  logic       bias_ok_i,
    input  logic       drv_ok_i,
    input  logic       en_i,
    input  logic       mode_strap_i,
    input  logic       hs_gate_low_i,
    input  logic       ls_gate_low_i,
    input  logic       sw_low_i,
    output logic       hs_on_o,
    output logic       ls_on_o,
    output logic       mode_o,
    output logic       ready_o,
    output logic       fault_o
);

    logic active;
    logic mode_now;
    logic go;

    assign active = bias_ok_i & drv_ok_i & en_i;

    hb_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .bias_ok_i  (bias_ok_i),
        .strap_i    (mode_strap_i),
        .mode_now_o (mode_now),
        .mode_o     (mode_o)
    );

    hb_arm_ctrl #(.READY_CYC(READY_CYC)) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .tri_mode_i (mode_now),
        .cmd_i      (cmd_i),
        .go_o       (go),
        .ready_o    (ready_o)
    );

    hb_deadtime #(.TIMEOUT(TIMEOUT)) u_dt (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go),
        .en_i     (en_i),
        .cmd_i    (cmd_i),
        .hs_gl_i  (hs_gate_low_i),
        .ls_gl_i  (ls_gate_low_i),
        .sw_low_i (sw_low_i),
        .hs_o     (hs_on_o),
        .ls_o     (ls_on_o),
        .fault_o  (fault_o)
    );

    // R1: a missing rail clears both gates on the next edge
    p_rails_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bias_ok_i && drv_ok_i) |=> (!hs_on_o && !ls_on_o));

endmodule

// File: tb/hb_gate_seq_test.sv
`timescale 1ns/1ps
module hb_gate_seq_test;

    localparam int READY_CYC = 8;
    localparam int TIMEOUT   = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cmd;
    logic       bias_ok, drv_ok, en, strap;
    logic       hs_gl, ls_gl, sw_lo;
    logic       hs_on, ls_on, mode, ready, fault;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hb_gate_seq #(.READY_CYC(READY_CYC), .TIMEOUT(TIMEOUT)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd),
        .bias_ok_i     (bias_ok),
        .drv_ok_i      (drv_ok),
        .en_i          (en),
        .mode_strap_i  (strap),
        .hs_gate_low_i (hs_gl),
        .ls_gate_low_i (ls_gl),
        .sw_low_i      (sw_lo),
        .hs_on_o       (hs_on),
        .ls_on_o       (ls_on),
        .mode_o        (mode),
        .ready_o       (ready),
        .fault_o       (fault)
    );

    // vector: [11:8] requirement, [7:6] cmd, [5] hs_gl, [4] ls_gl, [3] sw_lo, [1] exp hs, [0] exp ls
    localparam logic [11:0] VEC [11] = '{
        {4'd7, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd6, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd7, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd7, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd6, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd6, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd6, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd8, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd8, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd8, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd8, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd = 2'b10; bias_ok = 1'b0; drv_ok = 1'b0; en = 1'b0;
        strap = 1'b0; hs_gl = 1'b1; ls_gl = 1'b1; sw_lo = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // reset state, rails down (R1, R11, R10, R3)
        chk("R1", "hs after reset", hs_on, 1'b0);
        chk("R1", "ls after reset", ls_on, 1'b0);
        chk("R11", "ready after reset", ready, 1'b0);
        chk("R10", "fault after reset", fault, 1'b0);
        chk("R3", "mode after reset", mode, 1'b0);

        // R2: rails good, enable low, command high
        bias_ok = 1'b1; drv_ok = 1'b1; cmd = 2'b01;
        cyc(3);
        chk("R2", "hs with enable low", hs_on, 1'b0);
        // R5: standard mode switches without float exit
        en = 1'b1;
        cyc(3);
        chk("R5", "hs in standard mode", hs_on, 1'b1);
        chk("R3", "mode standard", mode, 1'b0);

        // table: R6, R7, R8
        for (int i = 0; i < 11; i++) begin
            cmd   = VEC[i][7:6];
            hs_gl = VEC[i][5];
            ls_gl = VEC[i][4];
            sw_lo = VEC[i][3];
            cyc(4);
            chk($sformatf("R%0d", VEC[i][11:8]), $sformatf("vec %0d hs", i), hs_on, VEC[i][1]);
            chk($sformatf("R%0d", VEC[i][11:8]), $sformatf("vec %0d ls", i), ls_on, VEC[i][0]);
        end

        // R1: drive rail drop
        cmd = 2'b00;
        cyc(4);
        chk("R1", "ls before rail drop", ls_on, 1'b1);
        drv_ok = 1'b0;
        cyc(1);
        chk("R1", "ls after rail drop", ls_on, 1'b0);
        chk("R1", "hs after rail drop", hs_on, 1'b0);
        drv_ok = 1'b1;
        cyc(4);
        chk("R1", "ls after rail back", ls_on, 1'b1);

        // R10: dead-time timeout
        cmd = 2'b01; ls_gl = 1'b0;
        cyc(10);
        chk("R10", "no early fault", fault, 1'b0);
        chk("R7", "hs held while waiting", hs_on, 1'b0);
        cyc(12);
        chk("R10", "fault after timeout", fault, 1'b1);
        ls_gl = 1'b1;
        cyc(4);
        chk("R10", "hs held under fault", hs_on, 1'b0);
        chk("R10", "fault sticky", fault, 1'b1);
        en = 1'b0;
        cyc(1);
        chk("R10", "fault cleared by enable low", fault, 1'b0);

        // R11: ready window
        cyc(2);
        en = 1'b1;
        cyc(READY_CYC - 1);
        chk("R11", "ready one edge early", ready, 1'b0);
        cyc(1);
        chk("R11", "ready on time", ready, 1'b1);
        chk("R10", "switching resumes after clear", hs_on, 1'b1);
        bias_ok = 1'b0;
        cyc(1);
        chk("R11", "ready drops with rail", ready, 1'b0);

        // R3: bias rail rise resamples strap; then R4 tri-level arming
        strap = 1'b1; cmd = 2'b01;
        cyc(1);
        bias_ok = 1'b1;
        cyc(1);
        chk("R3", "mode on bias rise", mode, 1'b1);
        cyc(5);
        chk("R4", "hs locked before float exit", hs_on, 1'b0);
        cmd = 2'b10;
        cyc(2);
        cmd = 2'b01;
        cyc(3);
        chk("R4", "hs after float exit", hs_on, 1'b1);
        strap = 1'b0;
        cyc(2);
        chk("R3", "mode frozen while enabled", mode, 1'b1);
        cmd = 2'b11;
        cyc(1);
        chk("R8", "float clears hs", hs_on, 1'b0);
        cmd = 2'b01;
        cyc(2);
        chk("R8", "resume without re-arm", hs_on, 1'b1);

        // R3 enable rise resamples; R9, R6, R7 under random flag delays
        en = 1'b0;
        cyc(1);
        en = 1'b1;
        cyc(1);
        chk("R3", "mode on enable rise", mode, 1'b0);
        cyc(2);
        begin
            logic ph, pl, pc_low, pc_high, phg, plg, psw;
            int   bad = 0;
            ph = hs_on; pl = ls_on;
            pc_low = (cmd == 2'b00); pc_high = (cmd == 2'b01);
            phg = hs_gl; plg = ls_gl; psw = sw_lo;
            for (int k = 0; k < 600; k++) begin
                logic [3:0] r;
                r     = 4'($urandom());
                cmd   = (r[3:2] == 2'b11) ? 2'b10 : {1'b0, r[0]};
                hs_gl = (2'($urandom()) != 2'b00);
                ls_gl = (2'($urandom()) != 2'b00);
                sw_lo = (2'($urandom()) != 2'b00);
                pc_low = (cmd == 2'b00); pc_high = (cmd == 2'b01);
                phg = hs_gl; plg = ls_gl; psw = sw_lo;
                cyc(1);
                n_run++;
                if (hs_on && ls_on) begin
                    bad++; n_fail++;
                    $display("FAIL R9 overlap step %0d: actual hs=1 ls=1 expected not both", k);
                end
                n_run++;
                if (ls_on && !pl && !(pc_low && !ph && phg && psw)) begin
                    bad++; n_fail++;
                    $display("FAIL R6 early ls step %0d: actual ls=1 expected 0", k);
                end
                n_run++;
                if (hs_on && !ph && !(pc_high && !pl && plg)) begin
                    bad++; n_fail++;
                    $display("FAIL R7 early hs step %0d: actual hs=1 expected 0", k);
                end
                ph = hs_on; pl = ls_on;
                if (bad > 10) break;
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule